// File: doc/BRIEF.md
# Outstanding Request Timeout Tracker

This block is the request front end of a memory-mapped I/O slave. Reads and writes arrive on two slave ports, each with an address, a burst count and a waitrequest output. Accepted requests are queued toward a transmit port, where a downstream packet builder takes them one at a time with a valid/ready handshake. A read, or a write that asks for a response, receives a tag from an eight-entry outstanding table. Its deadline is the sum of a programmable timeout value and a shared free-running tick counter.

Responses come back as a tag with a valid strobe. A response retires the matching live entry. An entry whose deadline is reached before its response arrives produces a one-cycle timeout pulse that carries its tag, and the entry is freed. A parameter chooses the queue arrangement. The first is one merged queue that keeps the order in which requests appeared on the ports. The second is separate read and write queues that are served alternately. A counter of accepted writes is available as an output.

Top module: `req_timeout_tracker`

## Requirements
- R1: A write accepted with `wr_resp` = 0 is posted. It is forwarded with `tx_tracked` = 0 and never produces a timeout pulse.
- R2: Tracked requests take the lowest-numbered free tag. When a read and a tracked write are accepted in the same cycle, the read takes the lowest free tag and the write takes the next-lowest. The tag is forwarded on `tx_tag`.
- R3: A tracked entry's deadline is the tick counter value at the acceptance edge plus `timeout_val`, modulo 2^CNT_W. If no response arrives, `to_pulse` is high for exactly one cycle, `timeout_val` cycles after the acceptance edge, with `to_tag` set to the entry's tag. This holds for any `timeout_val` from 1 to 2^CNT_W-1, including when the sum wraps.
- R4: A response whose `rsp_tag` names a live entry retires it, so that entry produces no timeout. A response that names an idle tag changes nothing.
- R5: When several entries expire in the same cycle, one is reported per cycle in ascending tag order. Each reported entry is freed.
- R6: With ORDERED = 1, reads and writes share one queue and leave on the transmit port in the order they were accepted. A read and a write accepted in the same cycle leave read first.
- R7: With ORDERED = 0, reads and writes use separate queues. When both queues hold requests, the transmit port alternates between them, and every accepted request is forwarded.
- R8: A port's waitrequest is high while its queue has no room for the request. `rd_wait` is also high while no tag is free. `wr_wait` is also high while `wr_resp` = 1 and no tag is left after a same-cycle read. A posted write is not blocked by tag exhaustion.
- R9: `wr_count` increments by one for every accepted write, tracked or posted, and wraps at 2^WCNT_W.
- R10: After reset both waitrequests are low, the queue is empty, no timeout is pending and `wr_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_burst | input | BURST_W | Read burst count |
| rd_wait | output | 1 | Read waitrequest |
| wr_req | input | 1 | Write request strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_burst | input | BURST_W | Write burst count |
| wr_resp | input | 1 | Write expects a response (tracked) |
| wr_wait | output | 1 | Write waitrequest |
| timeout_val | input | CNT_W | Programmable timeout in ticks |
| tx_valid | output | 1 | Queue head valid |
| tx_ready | input | 1 | Transmit side takes the head |
| tx_is_wr | output | 1 | Head is a write |
| tx_tracked | output | 1 | Head expects a response |
| tx_tag | output | TAG_W | Tag of the head |
| tx_addr | output | ADDR_W | Address of the head |
| tx_burst | output | BURST_W | Burst count of the head |
| rsp_valid | input | 1 | Response arrived |
| rsp_tag | input | TAG_W | Tag of the response |
| to_pulse | output | 1 | Timeout report strobe |
| to_tag | output | TAG_W | Tag that timed out |
| wr_count | output | WCNT_W | Accepted write count |

## Verification
A wrong deadline or a stuck tick counter shows up as a timeout pulse that arrives early, arrives late or never arrives. The bench measures this against `timeout_val` to the cycle, across values that wrap the counter. A corrupted busy or pending bit shows at the ports in two ways. It can show as a spurious or duplicated `to_pulse`. It can also show as waitrequest asserting too early or staying high, in the cycle after the table state changes. Queue pointer errors change the sequence of `tx_is_wr` and `tx_tag` values at the very next pop.

// File: rtl/req_timeout_tracker.sv
module req_timeout_tracker #(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 4,
  parameter int NTAG    = 8,
  parameter int CNT_W   = 8,
  parameter int QD      = 4,
  parameter int WCNT_W  = 16,
  parameter bit ORDERED = 1'b1,
  localparam int TAG_W  = $clog2(NTAG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [BURST_W-1:0] rd_burst,
  output logic               rd_wait,
  input  logic               wr_req,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BURST_W-1:0] wr_burst,
  input  logic               wr_resp,
  output logic               wr_wait,
  input  logic [CNT_W-1:0]   timeout_val,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic               tx_is_wr,
  output logic               tx_tracked,
  output logic [TAG_W-1:0]   tx_tag,
  output logic [ADDR_W-1:0]  tx_addr,
  output logic [BURST_W-1:0] tx_burst,
  input  logic               rsp_valid,
  input  logic [TAG_W-1:0]   rsp_tag,
  output logic               to_pulse,
  output logic [TAG_W-1:0]   to_tag,
  output logic [WCNT_W-1:0]  wr_count
);
  localparam int PW  = $clog2(QD);
  localparam int E_W = ADDR_W + BURST_W + TAG_W + 2;
  localparam logic [NTAG-1:0] ONE = NTAG'(1);

  function automatic logic [TAG_W:0] lowest(input logic [NTAG-1:0] m);
    lowest = '0;
    for (int i = NTAG - 1; i >= 0; i--)
      if (m[i]) lowest = {1'b1, TAG_W'(i)};
  endfunction

  logic [CNT_W-1:0] tick;
  logic [NTAG-1:0]  busy, pend, exp_now, rd_mask, wr_mask, rsp_mask, rep_mask;
  logic [CNT_W-1:0] dl [NTAG];
  logic [TAG_W:0]   f1, f2, pl;
  logic             rd_acc, wr_acc, rd_qfull, wr_qfull, pop;
  logic [E_W-1:0]   rd_ent, wr_ent, head;

  assign f1       = lowest(~busy);
  assign rd_wait  = rd_qfull | ~f1[TAG_W];
  assign rd_acc   = rd_req & ~rd_wait;
  assign rd_mask  = rd_acc ? (ONE << f1[TAG_W-1:0]) : '0;
  assign f2       = lowest(~busy & ~rd_mask);
  assign wr_wait  = wr_qfull | (wr_resp & ~f2[TAG_W]);
  assign wr_acc   = wr_req & ~wr_wait;
  assign wr_mask  = (wr_acc & wr_resp) ? (ONE << f2[TAG_W-1:0]) : '0;
  assign rsp_mask = rsp_valid ? (ONE << rsp_tag) : '0;
  assign pl       = lowest(pend);
  assign to_pulse = pl[TAG_W];
  assign to_tag   = pl[TAG_W-1:0];
  assign rep_mask = to_pulse ? (ONE << to_tag) : '0;

  always_comb
    for (int i = 0; i < NTAG; i++)
      exp_now[i] = busy[i] & ~pend[i] & (tick == dl[i]) & ~rsp_mask[i];

  assign rd_ent = {1'b0, 1'b1, f1[TAG_W-1:0], rd_burst, rd_addr};
  assign wr_ent = {1'b1, wr_resp, wr_resp ? f2[TAG_W-1:0] : TAG_W'(0), wr_burst, wr_addr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick     <= '0;
      busy     <= '0;
      pend     <= '0;
      wr_count <= '0;
    end else begin
      tick     <= tick + CNT_W'(1);
      busy     <= (busy & ~rsp_mask & ~rep_mask) | rd_mask | wr_mask;
      pend     <= (pend | exp_now) & ~rsp_mask & ~rep_mask;
      wr_count <= wr_count + WCNT_W'(wr_acc);
    end
  end

  always_ff @(posedge clk) begin
    if (rd_acc) dl[f1[TAG_W-1:0]] <= tick + timeout_val;
    if (wr_acc && wr_resp) dl[f2[TAG_W-1:0]] <= tick + timeout_val;
  end

  assign pop = tx_valid & tx_ready;

  generate
    if (ORDERED) begin : g_merged
      logic [E_W-1:0] q [QD];
      logic [PW-1:0]  wp, rp;
      logic [PW:0]    cnt;
      assign rd_qfull = cnt == (PW+1)'(QD);
      assign wr_qfull = ({1'b0, cnt} + (PW+2)'(rd_acc)) >= (PW+2)'(QD);
      assign tx_valid = cnt != '0;
      assign head     = q[rp];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wp <= '0; rp <= '0; cnt <= '0;
        end else begin
          wp  <= wp + PW'(rd_acc) + PW'(wr_acc);
          rp  <= rp + PW'(pop);
          cnt <= cnt + (PW+1)'(rd_acc) + (PW+1)'(wr_acc) - (PW+1)'(pop);
        end
      end
      always_ff @(posedge clk) begin
        if (rd_acc) q[wp] <= rd_ent;
        if (wr_acc) q[wp + PW'(rd_acc)] <= wr_ent;
      end
      a_r8_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (PW+1)'(QD));
    end else begin : g_split
      logic [E_W-1:0] rq [QD];
      logic [E_W-1:0] wq [QD];
      logic [PW-1:0]  rwp, rrp, wwp, wrp;
      logic [PW:0]    rcnt, wcnt;
      logic           rr, sel_w;
      assign rd_qfull = rcnt == (PW+1)'(QD);
      assign wr_qfull = wcnt == (PW+1)'(QD);
      assign tx_valid = (rcnt != '0) | (wcnt != '0);
      assign sel_w    = (wcnt != '0) & ((rcnt == '0) | rr);
      assign head     = sel_w ? wq[wrp] : rq[rrp];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rwp <= '0; rrp <= '0; wwp <= '0; wrp <= '0;
          rcnt <= '0; wcnt <= '0; rr <= 1'b0;
        end else begin
          rwp  <= rwp + PW'(rd_acc);
          wwp  <= wwp + PW'(wr_acc);
          rrp  <= rrp + PW'(pop & ~sel_w);
          wrp  <= wrp + PW'(pop & sel_w);
          rcnt <= rcnt + (PW+1)'(rd_acc) - (PW+1)'(pop & ~sel_w);
          wcnt <= wcnt + (PW+1)'(wr_acc) - (PW+1)'(pop & sel_w);
          if (pop) rr <= ~sel_w;
        end
      end
      always_ff @(posedge clk) begin
        if (rd_acc) rq[rwp] <= rd_ent;
        if (wr_acc) wq[wwp] <= wr_ent;
      end
      a_r8_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rcnt <= (PW+1)'(QD)) && (wcnt <= (PW+1)'(QD)));
    end
  endgenerate

  assign tx_addr    = head[ADDR_W-1:0];
  assign tx_burst   = head[ADDR_W +: BURST_W];
  assign tx_tag     = head[ADDR_W+BURST_W +: TAG_W];
  assign tx_tracked = head[E_W-2];
  assign tx_is_wr   = head[E_W-1];

  a_r5_pulse_tracked: assert property (@(posedge clk) disable iff (!rst_n)
    to_pulse |-> busy[to_tag]);
  a_r5_pulse_frees: assert property (@(posedge clk) disable iff (!rst_n)
    to_pulse |=> !busy[$past(to_tag)]);
  a_r4_rsp_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && busy[rsp_tag]) |=> !busy[$past(rsp_tag)]);
  a_r2_alloc_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_mask & wr_mask) == 0);
endmodule

// File: tb/tb_req_timeout_tracker.sv
module tb_req_timeout_tracker;
  localparam int ADDR_W = 16, BURST_W = 4, CNT_W = 8, WCNT_W = 16, TAG_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req = 0, wr_req = 0, wr_resp = 0, tx_ready = 1, rsp_valid = 0;
  logic [ADDR_W-1:0] rd_addr = '0, wr_addr = '0;
  logic [BURST_W-1:0] rd_burst = '0, wr_burst = '0;
  logic [CNT_W-1:0] timeout_val = 8'd3;
  logic [TAG_W-1:0] rsp_tag = '0;
  logic rd_wait, wr_wait, tx_valid, tx_is_wr, tx_tracked, to_pulse;
  logic [TAG_W-1:0] tx_tag, to_tag;
  logic [ADDR_W-1:0] tx_addr;
  logic [BURST_W-1:0] tx_burst;
  logic [WCNT_W-1:0] wr_count;
  logic u_rd_wait, u_wr_wait, u_tx_valid, u_tx_is_wr, u_tx_tracked, u_to_pulse;
  logic [TAG_W-1:0] u_tx_tag, u_to_tag;
  logic [ADDR_W-1:0] u_tx_addr;
  logic [BURST_W-1:0] u_tx_burst;
  logic [WCNT_W-1:0] u_wr_count;

  always #5 clk = ~clk;

  req_timeout_tracker dut (.clk, .rst_n, .rd_req, .rd_addr, .rd_burst, .rd_wait,
    .wr_req, .wr_addr, .wr_burst, .wr_resp, .wr_wait, .timeout_val, .tx_valid,
    .tx_ready, .tx_is_wr, .tx_tracked, .tx_tag, .tx_addr, .tx_burst, .rsp_valid,
    .rsp_tag, .to_pulse, .to_tag, .wr_count);

  req_timeout_tracker #(.ORDERED(1'b0)) dut_u (.clk, .rst_n, .rd_req, .rd_addr,
    .rd_burst, .rd_wait(u_rd_wait), .wr_req, .wr_addr, .wr_burst, .wr_resp,
    .wr_wait(u_wr_wait), .timeout_val, .tx_valid(u_tx_valid), .tx_ready,
    .tx_is_wr(u_tx_is_wr), .tx_tracked(u_tx_tracked), .tx_tag(u_tx_tag),
    .tx_addr(u_tx_addr), .tx_burst(u_tx_burst), .rsp_valid, .rsp_tag,
    .to_pulse(u_to_pulse), .to_tag(u_to_tag), .wr_count(u_wr_count));

  int checks = 0, failures = 0;
  bit done = 0;

  localparam int NV = 5;
  localparam int VEC_TO  [NV] = '{3, 5, 1, 17, 250};
  localparam int VEC_DLY [NV] = '{3, 5, 1, 17, 250};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int v, input bit rsp_en, input int rt, output int n, output int tg);
    @(negedge clk); timeout_val = CNT_W'(v); rd_req = 1; rd_addr = 16'h1234;
    @(negedge clk); rd_req = 0; n = 0;
    while (!to_pulse && n < 300) begin
      @(negedge clk); n++;
      if (n == 2 && rsp_en) begin rsp_valid = 1; rsp_tag = TAG_W'(rt); end
      else rsp_valid = 0;
    end
    tg = to_tag;
    rsp_valid = 0;
    @(negedge clk);
  endtask

  task automatic respond(input int t);
    @(negedge clk); rsp_valid = 1; rsp_tag = TAG_W'(t);
    @(negedge clk); rsp_valid = 0;
  endtask

  initial begin
    int n, tg, pulses, wexp;
    int seq [4];
    int useq [4];
    int ur, uw;
    wexp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_wait && !wr_wait, "R10 waits after reset", rd_wait + wr_wait, 0);
    chk(!tx_valid && !to_pulse, "R10 queue/timeout after reset", tx_valid + to_pulse, 0);
    chk(wr_count == 0, "R10 wr_count after reset", wr_count, 0);

    for (int i = 0; i < NV; i++) begin
      measure(VEC_TO[i], 0, 0, n, tg);
      chk(n == VEC_DLY[i], "R3 timeout delay", n, VEC_DLY[i]);
      chk(tg == 0, "R3 timeout tag", tg, 0);
    end

    measure(10, 1, 5, n, tg);
    chk(n == 10, "R4 idle-tag response ignored", n, 10);
    measure(10, 1, 0, n, tg);
    chk(n == 300, "R4 live response retires", n, 300);

    @(negedge clk); timeout_val = 8'd6; rd_req = 1; wr_req = 1; wr_resp = 1;
    @(negedge clk); rd_req = 0; wr_req = 0; wr_resp = 0; wexp++; n = 0;
    while (!to_pulse && n < 50) begin @(negedge clk); n++; end
    chk(n == 6 && to_tag == 0, "R5 first expiry is tag 0", to_tag, 0);
    @(negedge clk);
    chk(to_pulse && to_tag == 1, "R5/R2 second expiry is tag 1", to_tag, 1);
    @(negedge clk);
    chk(!to_pulse, "R5 entries freed after report", to_pulse, 0);

    @(negedge clk); timeout_val = 8'd3; wr_req = 1; wr_resp = 0;
    @(negedge clk); wr_req = 0; wexp++;
    chk(tx_valid && tx_is_wr && !tx_tracked, "R1 posted write forwarded untracked", tx_tracked, 0);
    pulses = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); pulses += to_pulse; end
    chk(pulses == 0, "R1 posted write never times out", pulses, 0);
    chk(wr_count == WCNT_W'(wexp), "R9 write count", wr_count, wexp);

    timeout_val = 8'd250;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rd_req = 1;
      @(negedge clk); rd_req = 0;
      chk(tx_valid && tx_tag == TAG_W'(i), "R2 lowest free tag", tx_tag, i);
    end
    @(negedge clk);
    chk(rd_wait, "R8 rd_wait with no free tag", rd_wait, 1);
    wr_resp = 1; #1;
    chk(wr_wait, "R8 tracked write blocked by tags", wr_wait, 1);
    wr_resp = 0; #1;
    chk(!wr_wait, "R8 posted write not blocked by tags", wr_wait, 0);
    for (int i = 0; i < 8; i++) respond(i);
    chk(!rd_wait, "R8 rd_wait released after retire", rd_wait, 0);

    @(negedge clk); tx_ready = 0;
    for (int i = 0; i < 4; i++) begin
      chk(!rd_wait, "R8 room in queue", rd_wait, 0);
      rd_req = 1; @(negedge clk); rd_req = 0;
    end
    chk(rd_wait && wr_wait, "R8 waits with full queue", rd_wait + wr_wait, 2);
    tx_ready = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) respond(i);
    chk(!rd_wait && !wr_wait && !tx_valid, "R8 waits released after drain", rd_wait + wr_wait, 0);

    tx_ready = 0;
    rd_req = 1; wr_req = 1; wr_resp = 0;
    @(negedge clk); rd_req = 0;
    @(negedge clk); wr_req = 0; rd_req = 1;
    @(negedge clk); rd_req = 0; wexp += 2;
    tx_ready = 1;
    for (int k = 0; k < 4; k++) begin
      seq[k] = tx_valid ? int'(tx_is_wr) : 9;
      useq[k] = u_tx_valid ? int'(u_tx_is_wr) : 9;
      @(negedge clk);
    end
    chk(seq[0] == 0, "R6 same-cycle read first", seq[0], 0);
    chk(seq[1] == 1 && seq[2] == 1, "R6 writes in order", seq[1] + seq[2], 2);
    chk(seq[3] == 0, "R6 later read last", seq[3], 0);
    ur = 0; uw = 0;
    for (int k = 0; k < 4; k++) begin
      if (useq[k] == 0) ur++;
      if (useq[k] == 1) uw++;
    end
    chk(ur == 2 && uw == 2, "R7 split queues forward all", ur * 10 + uw, 22);
    chk(useq[0] != useq[1] && useq[1] != useq[2] && useq[2] != useq[3],
        "R7 split queues alternate", useq[1], 1 - useq[0]);
    respond(0); respond(1);
    chk(wr_count == WCNT_W'(wexp), "R9 write count final", wr_count, wexp);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule